// File: doc/BRIEF.md
# Random Generator Control and Status Registers

This block is the register front end of a random number generator. A host reaches it over a simple single-cycle register bus with an address, a write strobe with write data and a read strobe with combinational read data. It holds a version word, a command port, a control word, a status word and a random output port. A 32-bit maximal-length LFSR stands in for the entropy source.

Two background operations, seeding and self-test, can be started from the command port. Each one moves from idle to running, stays in running for a fixed number of clock cycles, and then settles in done. Completion is shown in status and in the command readback. It also raises a level interrupt unless completion interrupts are masked. Software can clear the interrupt and can reset the block's soft state through the command port. Status always reports a full five-word output queue, a fresh seed, and one of busy or ready.

Top module: `rng_ctrl_regs`

## Requirements
- R1: Reads decode offset 0x00 (version), 0x04 (command), 0x08 (control), 0x0C (status) and 0x14 (random output). Every other offset reads 0. The version word is 0x1000_0240: type 1 in bits 31:28, major 2 at bits 15:8, minor 0x40 in bits 7:0. Read data is 0 while the read strobe is low.
- R2: A command write with a bit set triggers its action: bit 6 software reset, bit 5 clear error, bit 4 clear interrupt, bit 1 start seed, bit 0 start self-test. One write may carry several bits. A command read shows bit 1 while seeding runs and bit 0 while self-test runs. All other command bits read 0.
- R3: A start write committed at clock edge E puts its operation in running. The operation enters done at edge E+RUN_CYCLES (default 16). A start issued while the operation is running or done reloads the full count.
- R4: At the edge where an operation enters done, the interrupt output goes high if control bit 5 (mask done) is clear. If that bit is set, the interrupt stays low.
- R5: A command write with bit 5 or bit 4 set drives the interrupt low after that edge.
- R6: Control bits 6 (mask error), 5 (mask done) and 4 (auto seed) are stored on write and read back. All other control bits read 0 whatever was written.
- R7: Status bits 15:12 and 11:8 each read 5. Bit 6 always reads 1. Bit 5 reads 1 when seeding is done and bit 4 reads 1 when self-test is done. All other bits not named in R8 read 0.
- R8: Status bit 1 (busy) is 1 while either operation runs. Otherwise status bit 0 (ready) is 1. The two bits are never both 1.
- R9: A software reset returns both operations to idle and clears control bits 6, 5 and 4. It leaves the interrupt unchanged. A hardware reset clears all of this, clears the interrupt and reloads the LFSR seed.
- R10: When one command write carries both software reset and a start bit, the reset is applied first and the started operation is left running.
- R11: A read of 0x14 returns the LFSR value, which starts at 0x1D87_2B41. Each such read advances it once by shifting left and inserting bit31^bit21^bit1^bit0 at bit 0. No other access advances it, and its value is never zero.
- R12: Writes to the version, status and random output offsets change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; also advances the LFSR when addr is 0x14 |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, operation completion |

## Verification
The hardest case to reach is a command write that is both a software reset and a start. The stimulus first sets every control bit and then issues that write. It checks that the started operation reads back as running, that the control word reads zero, and that the operation's completion now raises the interrupt, which it could only do with mask done cleared. A second hard case is the restart rule. Seeding is started again eight cycles into a run, and the interrupt is sampled one cycle before and exactly at the new completion edge. This shows that the first count was discarded. The exact edge of completion is pinned the same way for an uninterrupted self-test.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RUN  = 2'd1,
      OP_DONE = 2'd2
   } op_state_e;

   localparam int unsigned OFS_VER  = 'h00;
   localparam int unsigned OFS_CMD  = 'h04;
   localparam int unsigned OFS_CTRL = 'h08;
   localparam int unsigned OFS_STAT = 'h0C;
   localparam int unsigned OFS_RAND = 'h14;

   localparam int unsigned CMD_SOFT_RST = 6;
   localparam int unsigned CMD_CLR_ERR  = 5;
   localparam int unsigned CMD_CLR_IRQ  = 4;
   localparam int unsigned CMD_SEED     = 1;
   localparam int unsigned CMD_TEST     = 0;

   localparam int unsigned CTL_MASK_ERR  = 6;
   localparam int unsigned CTL_MASK_DONE = 5;
   localparam int unsigned CTL_AUTO_SEED = 4;

endpackage

// File: rtl/rng_op_seq.sv
module rng_op_seq
   import rngc_pkg::*;
#(
   parameter int unsigned RUN_CYCLES = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      soft_clr,
   input  logic      start,
   output op_state_e state_o,
   output logic      done_o
);

   localparam int unsigned CW = $clog2(RUN_CYCLES + 1);
   localparam logic [CW-1:0] RELOAD = CW'(RUN_CYCLES - 1);

   generate
      if (RUN_CYCLES < 1) begin : g_bad_len
         $error("rng_op_seq: RUN_CYCLES must be at least 1");
      end
   endgenerate

   op_state_e      state_q;
   logic [CW-1:0]  cnt_q;

   always_comb begin
      done_o = (state_q == OP_RUN) && (cnt_q == '0) && !start && !soft_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OP_IDLE;
         cnt_q   <= '0;
      end else if (start) begin
         state_q <= OP_RUN;
         cnt_q   <= RELOAD;
      end else if (soft_clr) begin
         state_q <= OP_IDLE;
         cnt_q   <= '0;
      end else if (state_q == OP_RUN) begin
         if (cnt_q == '0) begin
            state_q <= OP_DONE;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] SEED = W'(32'h1D87_2B41)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r;
   logic         fb;

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("rng_lfsr: SEED must be nonzero");
      end
      if (W == 32) begin : g_taps32
         always_comb fb = q_r[31] ^ q_r[21] ^ q_r[1] ^ q_r[0];
      end else if (W == 16) begin : g_taps16
         always_comb fb = q_r[15] ^ q_r[13] ^ q_r[12] ^ q_r[10];
      end else begin : g_bad_w
         $error("rng_lfsr: only widths 16 and 32 are supported");
         always_comb fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= SEED;
      end else if (adv) begin
         q_r <= {q_r[W-2:0], fb};
      end
   end

   assign q = q_r;

endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
   import rngc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned RUN_CYCLES = 16,
   parameter int unsigned FIFO_WORDS = 5,
   parameter int unsigned VER_TYPE   = 1,
   parameter int unsigned VER_MAJ    = 2,
   parameter int unsigned VER_MIN    = 'h40,
   parameter logic [31:0] LFSR_SEED  = 32'h1D87_2B41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   output logic [31:0]       rd_data,
   output logic              irq
);

   localparam logic [31:0] CTRL_KEEP =
      (32'd1 << CTL_MASK_ERR) | (32'd1 << CTL_MASK_DONE) | (32'd1 << CTL_AUTO_SEED);
   localparam logic [31:0] VER_WORD =
      (32'(VER_TYPE) << 28) | (32'(VER_MAJ) << 8) | 32'(VER_MIN);

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("rng_ctrl_regs: ADDR_W too narrow for the register map");
      end
      if (FIFO_WORDS > 15) begin : g_bad_fifo
         $error("rng_ctrl_regs: FIFO_WORDS must fit in four bits");
      end
      if (VER_TYPE > 15 || VER_MAJ > 255 || VER_MIN > 255) begin : g_bad_ver
         $error("rng_ctrl_regs: version field out of range");
      end
   endgenerate

   // address decode
   logic sel_ver, sel_cmd, sel_ctrl, sel_stat, sel_rand;
   always_comb begin
      sel_ver  = (addr == ADDR_W'(OFS_VER));
      sel_cmd  = (addr == ADDR_W'(OFS_CMD));
      sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
      sel_stat = (addr == ADDR_W'(OFS_STAT));
      sel_rand = (addr == ADDR_W'(OFS_RAND));
   end

   // command strobes
   logic cmd_wr, soft_rst, clr_irq, seed_go, test_go;
   always_comb begin
      cmd_wr   = wr_en && sel_cmd;
      soft_rst = cmd_wr && wr_data[CMD_SOFT_RST];
      clr_irq  = cmd_wr && (wr_data[CMD_CLR_ERR] || wr_data[CMD_CLR_IRQ]);
      seed_go  = cmd_wr && wr_data[CMD_SEED];
      test_go  = cmd_wr && wr_data[CMD_TEST];
   end

   // seed and self-test sequencers
   op_state_e seed_state, test_state;
   logic      seed_done, test_done;

   rng_op_seq #(.RUN_CYCLES(RUN_CYCLES)) u_seed_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_rst),
      .start    (seed_go),
      .state_o  (seed_state),
      .done_o   (seed_done)
   );

   rng_op_seq #(.RUN_CYCLES(RUN_CYCLES)) u_test_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_rst),
      .start    (test_go),
      .state_o  (test_state),
      .done_o   (test_done)
   );

   // control word
   logic [31:0] ctrl_q;
   logic        mask_done;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (soft_rst) begin
         ctrl_q <= '0;
      end else if (wr_en && sel_ctrl) begin
         ctrl_q <= wr_data & CTRL_KEEP;
      end
   end
   assign mask_done = ctrl_q[CTL_MASK_DONE];

   // interrupt line
   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if ((seed_done || test_done) && !mask_done) begin
         irq_q <= 1'b1;
      end else if (clr_irq) begin
         irq_q <= 1'b0;
      end
   end
   assign irq = irq_q;

   // random word source
   logic [31:0] lfsr_q;
   rng_lfsr #(.W(32), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rd_en && sel_rand),
      .q     (lfsr_q)
   );

   // readback words
   logic        seed_run, test_run, any_run;
   logic [31:0] cmd_word, stat_word;
   always_comb begin
      seed_run = (seed_state == OP_RUN);
      test_run = (test_state == OP_RUN);
      any_run  = seed_run || test_run;

      cmd_word = '0;
      cmd_word[CMD_SEED] = seed_run;
      cmd_word[CMD_TEST] = test_run;

      stat_word        = '0;
      stat_word[15:12] = 4'(FIFO_WORDS);
      stat_word[11:8]  = 4'(FIFO_WORDS);
      stat_word[6]     = 1'b1;
      stat_word[5]     = (seed_state == OP_DONE);
      stat_word[4]     = (test_state == OP_DONE);
      stat_word[1]     = any_run;
      stat_word[0]     = !any_run;
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (sel_ver)       rd_data = VER_WORD;
         else if (sel_cmd)  rd_data = cmd_word;
         else if (sel_ctrl) rd_data = ctrl_q;
         else if (sel_stat) rd_data = stat_word;
         else if (sel_rand) rd_data = lfsr_q;
      end
   end

endmodule

// File: rtl/rng_ctrl_regs_chk.sv
module rng_ctrl_regs_chk
   import rngc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FIFO_WORDS = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [31:0]       wr_data,
   input logic              rd_en,
   input logic [31:0]       rd_data,
   input logic              irq,
   input op_state_e         seed_st,
   input op_state_e         test_st,
   input logic              seed_done,
   input logic              test_done,
   input logic              mask_done,
   input logic [31:0]       lfsr_q
);

   // R2: command readback has only the two running bits
   a_r2_cmd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_CMD)) |-> (rd_data[31:2] == '0));

   // R3: an operation never jumps from idle straight to done
   a_r3_seed_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(seed_st) == OP_IDLE) |-> (seed_st != OP_DONE));

   a_r3_test_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(test_st) == OP_IDLE) |-> (test_st != OP_DONE));

   // R4: the interrupt rises only on an unmasked completion
   a_r4_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(!mask_done && (seed_done || test_done)));

   // R5: a clear write without a completion lowers the interrupt
   a_r5_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_CMD) && (wr_data[5] || wr_data[4])
       && !seed_done && !test_done) |=> !irq);

   // R7: constant status fields
   a_r7_status_const: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_STAT)) |->
      (rd_data[6] && rd_data[15:12] == 4'(FIFO_WORDS) && rd_data[11:8] == 4'(FIFO_WORDS)));

   // R8: busy and ready are exclusive
   a_r8_busy_xor_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_STAT)) |-> (rd_data[1] ^ rd_data[0]));

   // R11: the random source never locks at zero
   a_r11_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

endmodule

bind rng_ctrl_regs rng_ctrl_regs_chk #(
   .ADDR_W     (ADDR_W),
   .FIFO_WORDS (FIFO_WORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_en     (rd_en),
   .rd_data   (rd_data),
   .irq       (irq),
   .seed_st   (seed_state),
   .test_st   (test_state),
   .seed_done (seed_done),
   .test_done (test_done),
   .mask_done (mask_done),
   .lfsr_q    (lfsr_q)
);

// File: tb/rng_ctrl_regs_tb_top.sv
module rng_ctrl_regs_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RUN        = 16;
   localparam logic [31:0] SEED  = 32'h1D87_2B41;
   localparam logic [31:0] ST_IDLE = 32'h0000_5541;
   localparam logic [31:0] ST_BUSY = 32'h0000_5542;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] lf_model = SEED;

   always #(CLK_PERIOD/2) clk = ~clk;

   rng_ctrl_regs dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .irq     (irq)
   );

   function automatic logic [31:0] lf_next(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   // monitor: pops the expected word for each read strobe
   always @(negedge clk) begin
      if (rd_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read: actual %h expected none", rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(posedge clk); #1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      addr = a; rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic rd_rand(input string t);
      rd(8'h14, lf_model, t);
      lf_model = lf_next(lf_model);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: actual irq %b expected %b", t, irq, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      chk_irq(1'b0, "R9 irq after hw reset");
      rd(8'h00, 32'h1000_0240, "R1 version");
      rd(8'h04, 32'h0, "R2 cmd idle");
      rd(8'h08, 32'h0, "R6 ctrl reset");
      rd(8'h0C, ST_IDLE, "R7 R8 status idle");

      // unmapped offsets
      rd(8'h10, 32'h0, "R1 unmapped 0x10");
      rd(8'h18, 32'h0, "R1 unmapped 0x18");

      // read-only offsets ignore writes
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h14, 32'h0);
      rd(8'h00, 32'h1000_0240, "R12 version after write");
      rd(8'h0C, ST_IDLE, "R12 status after write");
      rd(8'h04, 32'h0, "R12 cmd after writes");

      // control bits
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, 32'h70, "R6 ctrl all ones");
      wr(8'h08, 32'h20);
      rd(8'h08, 32'h20, "R6 ctrl mask done");

      // masked seed
      wr(8'h04, 32'h2);
      rd(8'h04, 32'h2, "R2 cmd seed running");
      rd(8'h0C, ST_BUSY, "R8 status busy");
      repeat (RUN + 2) @(posedge clk);
      rd(8'h0C, ST_IDLE | 32'h20, "R7 seed done bit");
      chk_irq(1'b0, "R4 masked completion");
      rd(8'h04, 32'h0, "R2 cmd after seed done");

      // unmasked self-test, exact completion edge
      wr(8'h08, 32'h0);
      wr(8'h04, 32'h1);
      repeat (RUN - 1) @(posedge clk);
      chk_irq(1'b0, "R3 self-test one cycle early");
      @(posedge clk);
      chk_irq(1'b1, "R3 R4 self-test completion edge");
      rd(8'h0C, ST_IDLE | 32'h30, "R7 both done bits");

      // clear via bit 4, restart rule, clear via bit 5
      wr(8'h04, 32'h10);
      chk_irq(1'b0, "R5 clear interrupt bit");
      wr(8'h04, 32'h2);
      repeat (8) @(posedge clk);
      wr(8'h04, 32'h2);
      repeat (RUN - 1) @(posedge clk);
      chk_irq(1'b0, "R3 restart discards first count");
      @(posedge clk);
      chk_irq(1'b1, "R3 restart completion edge");
      wr(8'h04, 32'h20);
      chk_irq(1'b0, "R5 clear error bit");

      // both starts in one write
      wr(8'h04, 32'h3);
      rd(8'h04, 32'h3, "R2 both running");
      rd(8'h0C, ST_BUSY, "R8 both busy");
      repeat (RUN + 2) @(posedge clk);
      rd(8'h0C, ST_IDLE | 32'h30, "R7 both done");
      chk_irq(1'b1, "R4 dual completion");
      wr(8'h04, 32'h30);
      chk_irq(1'b0, "R5 both clear bits");

      // software reset together with start
      wr(8'h08, 32'h70);
      wr(8'h04, 32'h41);
      rd(8'h04, 32'h1, "R10 start survives reset");
      rd(8'h08, 32'h0, "R10 ctrl cleared");
      rd(8'h0C, ST_BUSY, "R10 seed idle test running");
      repeat (RUN + 2) @(posedge clk);
      chk_irq(1'b1, "R10 mask cleared so irq rises");
      wr(8'h04, 32'h40);
      chk_irq(1'b1, "R9 soft reset keeps irq");
      rd(8'h0C, ST_IDLE, "R9 soft reset idles ops");

      // software reset during a run
      wr(8'h04, 32'h2);
      wr(8'h04, 32'h40);
      rd(8'h04, 32'h0, "R9 run aborted");
      repeat (RUN + 2) @(posedge clk);
      rd(8'h0C, ST_IDLE, "R9 aborted run never done");

      // random output
      rd_rand("R11 first word");
      rd(8'h0C, ST_IDLE, "R11 status read between");
      rd(8'h00, 32'h1000_0240, "R11 version read between");
      rd_rand("R11 second word");
      rd_rand("R11 third word");

      // hardware reset
      wr(8'h08, 32'h70);
      wr(8'h04, 32'h3);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      chk_irq(1'b0, "R9 hw reset clears irq");
      rd(8'h08, 32'h0, "R9 hw reset ctrl");
      rd(8'h04, 32'h0, "R9 hw reset cmd");
      rd(8'h0C, ST_IDLE, "R9 hw reset status");
      lf_model = SEED;
      rd_rand("R9 R11 lfsr reseeded");

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule